// File: doc/BRIEF.md
# Power-up protocol mode selector

This block sits at the pin boundary of a smart-card style memory device. It decides, once per power cycle, whether the device talks over a synchronous two-wire link or over an asynchronous character protocol. After the power-on-reset input `por` drops, it samples the reset and clock pins through synchronizers. If the reset pin is already high when sampling starts, the block selects the two-wire link. It then raises a ready flag once the host has supplied enough clock pulses.

If the reset pin is low at that moment, the block waits for the host to run the clock with reset held low. A later rising edge of reset is taken as a cold reset. The block locks into asynchronous mode and sends a fixed 64-bit answer-to-reset (ATR) on the data pin. The data pin is open-drain: the block only ever pulls it low or releases it. The ATR bytes are a parameter, so the historical bytes can carry the device density.

The block decides the mode and nothing more. Command decoding, memory access and rate negotiation belong to neighbouring logic.

Top module: `protosel_top`

## Requirements
- R1: If the reset pin is high when sampling starts after `por` drops, `mode_async` stays 0 (two-wire link). Later toggles of the reset pin leave it at 0.
- R2: If the reset pin is low when sampling starts, a later rising edge of the reset pin sets `mode_async` to 1 within 8 `clk` cycles.
- R3: `io_pull_low` stays 0 in two-wire mode, and stays 0 while waiting for the cold-reset rise.
- R4: The ATR starts only when two conditions hold: the reset rise has occurred, and COLD_CLKS card-clock rising edges have been counted while waiting. The count saturates at COLD_CLKS. An early rise therefore holds the ATR back until the COLD_CLKS-th edge.
- R5: Each ATR byte is a 12-bit frame, where pulled low means bit value 0:
  - bit 0 is a start bit, low;
  - bits 1 to 8 are the data bits, LSB first;
  - bit 9 is even parity, equal to the XOR of the data bits;
  - bits 10 and 11 are guard bits, released.

  Each bit lasts BIT_CLKS card-clock rising edges, counted from the start of the ATR. Byte k is ATR_VALUE[8k+7:8k], and byte 0 is sent first.
- R6: After the last guard bit of the last byte, `io_pull_low` returns to 0 and stays 0.
- R7: Once `mode_async` is 1, later activity on the reset or clock pins neither clears it nor starts a second ATR. Only `por` clears it.
- R8: `sync_ready` is 0 until the READY_CLKS-th card-clock rising edge in two-wire mode, and 1 from then on. It is never 1 in asynchronous mode.
- R9: While `por` is high, `mode_async`, `sync_ready` and `io_pull_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block sampling clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| card_clk | input | 1 | Card clock pin (asynchronous to `clk`) |
| card_rst | input | 1 | Card reset pin (asynchronous to `clk`) |
| io_pull_low | output | 1 | 1 pulls the data pin low; 0 releases it (reads high) |
| mode_async | output | 1 | 1 when the asynchronous protocol is selected |
| sync_ready | output | 1 | 1 when the two-wire link may accept commands |

## Verification
The bench targets the boundary of the cold-reset counter from both sides. A reset rise after the count has saturated must start the ATR at once. A rise after only three clocks must hold the ATR until the COLD_CLKS-th edge; a design that starts early pulls the line low too soon, and one that fails to saturate never starts at all. Every bit of all eight frames is compared against parity and LSB-first data computed in the bench, so a wrong bit order, parity polarity or bit length shows up as a mismatched bit index. It also checks that `sync_ready` flips exactly on the fifth edge, and that a second cold-reset sequence after the ATR neither clears the asynchronous lock nor sends the ATR again.

// File: rtl/protosel_pkg.sv
package protosel_pkg;

  typedef enum logic [2:0] {
    SEL_DECIDE,
    SEL_SYNC,
    SEL_ARM,
    SEL_ATR,
    SEL_LOCKED
  } sel_state_t;

  localparam int unsigned FRAME_BITS = 12;

  // Line level of frame bit idx for data byte b (1 = released/high)
  function automatic logic frame_level(input logic [7:0] b, input logic [3:0] idx);
    logic lvl;
    case (idx)
      4'd0:    lvl = 1'b0;
      4'd1, 4'd2, 4'd3, 4'd4,
      4'd5, 4'd6, 4'd7, 4'd8: lvl = b[idx - 4'd1];
      4'd9:    lvl = ^b;
      default: lvl = 1'b1;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/protosel_pin_sampler.sv
module protosel_pin_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic card_clk,
  input  logic card_rst,
  output logic primed,
  output logic rst_lvl,
  output logic clk_rise,
  output logic rst_rise
);
  localparam int unsigned FILL_W = $clog2(SYNC_STAGES + 2);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] clk_sh;
  logic [SYNC_STAGES-1:0] rst_sh;
  logic                   clk_q;
  logic                   rst_q;
  logic [FILL_W-1:0]      fill;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (por) begin
            clk_sh[0] <= 1'b0;
            rst_sh[0] <= 1'b0;
          end else begin
            clk_sh[0] <= card_clk;
            rst_sh[0] <= card_rst;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (por) begin
            clk_sh[g] <= 1'b0;
            rst_sh[g] <= 1'b0;
          end else begin
            clk_sh[g] <= clk_sh[g-1];
            rst_sh[g] <= rst_sh[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (por) begin
      clk_q <= 1'b0;
      rst_q <= 1'b0;
      fill  <= '0;
    end else begin
      clk_q <= clk_sh[SYNC_STAGES-1];
      rst_q <= rst_sh[SYNC_STAGES-1];
      if (fill != FILL_MAX) fill <= fill + 1'b1;
    end
  end

  assign primed   = (fill == FILL_MAX);
  assign rst_lvl  = rst_sh[SYNC_STAGES-1];
  assign clk_rise = primed & clk_sh[SYNC_STAGES-1] & ~clk_q;
  assign rst_rise = primed & rst_sh[SYNC_STAGES-1] & ~rst_q;

endmodule

// File: rtl/protosel_ready_ctr.sv
module protosel_ready_ctr #(
  parameter int unsigned READY_CLKS = 5
) (
  input  logic clk,
  input  logic por,
  input  logic enable,
  input  logic clk_rise,
  output logic ready
);
  localparam int unsigned CW = $clog2(READY_CLKS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(READY_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (por) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (enable && clk_rise && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_MAX - 1'b1) ready <= 1'b1;
    end
  end

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (por)
    ready |=> ready);

  p_ready_needs_enable_r8: assert property (@(posedge clk) disable iff (por)
    $rose(ready) |-> $past(enable));

endmodule

// File: rtl/protosel_atr_tx.sv
module protosel_atr_tx
  import protosel_pkg::*;
#(
  parameter int unsigned ATR_BYTES = 8,
  parameter int unsigned BIT_CLKS  = 372,
  parameter logic [8*ATR_BYTES-1:0] ATR_VALUE = '0
) (
  input  logic clk,
  input  logic por,
  input  logic start,
  input  logic clk_rise,
  output logic pull_low,
  output logic busy,
  output logic done
);
  localparam int unsigned TW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned BW = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;
  localparam logic [TW-1:0] TICK_LAST  = TW'(BIT_CLKS - 1);
  localparam logic [BW-1:0] BYTE_LAST  = BW'(ATR_BYTES - 1);
  localparam logic [3:0]    FRAME_LAST = 4'(FRAME_BITS - 1);

  logic [TW-1:0] tick;
  logic [3:0]    bidx;
  logic [BW-1:0] byte_sel;
  logic [7:0]    cur_byte;

  always_comb cur_byte = ATR_VALUE[8*int'(byte_sel) +: 8];

  always_ff @(posedge clk) begin
    if (por) begin
      tick     <= '0;
      bidx     <= '0;
      byte_sel <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      pull_low <= 1'b0;
    end else if (start) begin
      tick     <= '0;
      bidx     <= '0;
      byte_sel <= '0;
      busy     <= 1'b1;
      done     <= 1'b0;
      pull_low <= 1'b1;
    end else if (busy && clk_rise) begin
      if (tick == TICK_LAST) begin
        tick <= '0;
        if (bidx == FRAME_LAST) begin
          bidx <= '0;
          if (byte_sel == BYTE_LAST) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            pull_low <= 1'b0;
          end else begin
            byte_sel <= byte_sel + 1'b1;
            pull_low <= 1'b1;
          end
        end else begin
          bidx     <= bidx + 4'd1;
          pull_low <= ~frame_level(cur_byte, bidx + 4'd1);
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  p_release_when_idle_r3: assert property (@(posedge clk) disable iff (por)
    !busy |-> !pull_low);

  p_start_bit_r5: assert property (@(posedge clk) disable iff (por)
    $rose(busy) |-> pull_low);

  p_done_released_r6: assert property (@(posedge clk) disable iff (por)
    done |=> !pull_low);

endmodule

// File: rtl/protosel_mode_fsm.sv
module protosel_mode_fsm
  import protosel_pkg::*;
#(
  parameter int unsigned COLD_CLKS = 400
) (
  input  logic clk,
  input  logic por,
  input  logic primed,
  input  logic rst_lvl,
  input  logic rst_rise,
  input  logic clk_rise,
  input  logic atr_done,
  output logic mode_async,
  output logic sync_en,
  output logic atr_start
);
  localparam int unsigned CW = $clog2(COLD_CLKS + 1);
  localparam logic [CW-1:0] COLD_MAX = CW'(COLD_CLKS);

  sel_state_t    state;
  logic [CW-1:0] cold_cnt;
  logic          rise_seen;

  always_ff @(posedge clk) begin
    if (por) begin
      state      <= SEL_DECIDE;
      cold_cnt   <= '0;
      rise_seen  <= 1'b0;
      mode_async <= 1'b0;
      atr_start  <= 1'b0;
    end else begin
      atr_start <= 1'b0;
      case (state)
        SEL_DECIDE: begin
          if (primed) state <= rst_lvl ? SEL_SYNC : SEL_ARM;
        end
        SEL_SYNC: ;
        SEL_ARM: begin
          if (clk_rise && cold_cnt != COLD_MAX) cold_cnt <= cold_cnt + 1'b1;
          if (rst_rise) begin
            rise_seen  <= 1'b1;
            mode_async <= 1'b1;
          end
          if (rise_seen && cold_cnt == COLD_MAX) begin
            atr_start <= 1'b1;
            state     <= SEL_ATR;
          end
        end
        SEL_ATR: begin
          if (atr_done) state <= SEL_LOCKED;
        end
        default: state <= SEL_LOCKED;
      endcase
    end
  end

  assign sync_en = (state == SEL_SYNC);

  p_lock_r7: assert property (@(posedge clk) disable iff (por)
    mode_async |=> mode_async);

  p_start_needs_count_r4: assert property (@(posedge clk) disable iff (por)
    atr_start |-> (cold_cnt == COLD_MAX) && mode_async);

  p_sync_never_async_r1: assert property (@(posedge clk) disable iff (por)
    sync_en |-> !mode_async);

endmodule

// File: rtl/protosel_top.sv
module protosel_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned COLD_CLKS   = 400,
  parameter int unsigned READY_CLKS  = 5,
  parameter int unsigned BIT_CLKS    = 372,
  parameter int unsigned ATR_BYTES   = 8,
  parameter logic [8*ATR_BYTES-1:0] ATR_VALUE = 64'h0240_1000_0011_B23B
) (
  input  logic clk,
  input  logic por,
  input  logic card_clk,
  input  logic card_rst,
  output logic io_pull_low,
  output logic mode_async,
  output logic sync_ready
);
  logic primed, rst_lvl, clk_rise, rst_rise;
  logic sync_en, atr_start, atr_busy, atr_done;

  protosel_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk      (clk),
    .por      (por),
    .card_clk (card_clk),
    .card_rst (card_rst),
    .primed   (primed),
    .rst_lvl  (rst_lvl),
    .clk_rise (clk_rise),
    .rst_rise (rst_rise)
  );

  protosel_mode_fsm #(.COLD_CLKS(COLD_CLKS)) u_fsm (
    .clk        (clk),
    .por        (por),
    .primed     (primed),
    .rst_lvl    (rst_lvl),
    .rst_rise   (rst_rise),
    .clk_rise   (clk_rise),
    .atr_done   (atr_done),
    .mode_async (mode_async),
    .sync_en    (sync_en),
    .atr_start  (atr_start)
  );

  protosel_ready_ctr #(.READY_CLKS(READY_CLKS)) u_ready (
    .clk      (clk),
    .por      (por),
    .enable   (sync_en),
    .clk_rise (clk_rise),
    .ready    (sync_ready)
  );

  protosel_atr_tx #(
    .ATR_BYTES (ATR_BYTES),
    .BIT_CLKS  (BIT_CLKS),
    .ATR_VALUE (ATR_VALUE)
  ) u_atr (
    .clk      (clk),
    .por      (por),
    .start    (atr_start),
    .clk_rise (clk_rise),
    .pull_low (io_pull_low),
    .busy     (atr_busy),
    .done     (atr_done)
  );

  p_ready_sync_only_r8: assert property (@(posedge clk) disable iff (por)
    sync_ready |-> !mode_async);

  p_no_drive_in_sync_r3: assert property (@(posedge clk) disable iff (por)
    sync_en |-> !io_pull_low);

  always_ff @(posedge clk) begin
    if ($past(por) && !$isunknown($past(por))) begin
      p_por_clear_r9: assert (!mode_async && !sync_ready && !io_pull_low);
    end
  end

endmodule

// File: tb/tb_protosel_top.sv
module tb_protosel_top;
  localparam int CLK_PERIOD = 10;
  localparam int COLD  = 10;
  localparam int READY = 5;
  localparam int BITC  = 4;
  localparam int NB    = 8;
  localparam logic [63:0] ATRV = 64'hA500_FF3C_817E_113B;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic card_clk = 1'b0;
  logic card_rst = 1'b0;
  logic io_pull_low, mode_async, sync_ready;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  protosel_top #(
    .SYNC_STAGES (2),
    .COLD_CLKS   (COLD),
    .READY_CLKS  (READY),
    .BIT_CLKS    (BITC),
    .ATR_BYTES   (NB),
    .ATR_VALUE   (ATRV)
  ) dut (
    .clk         (clk),
    .por         (por),
    .card_clk    (card_clk),
    .card_rst    (card_rst),
    .io_pull_low (io_pull_low),
    .mode_async  (mode_async),
    .sync_ready  (sync_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic card_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      card_clk = 1'b1; wait_clk(SETTLE);
      card_clk = 1'b0; wait_clk(SETTLE);
    end
  endtask

  task automatic power_up(input logic rst_level);
    por = 1'b1; card_clk = 1'b0; card_rst = rst_level;
    wait_clk(4);
    chk(!mode_async && !sync_ready && !io_pull_low, "R9 por state", {mode_async, sync_ready, io_pull_low}, 0);
    por = 1'b0;
    wait_clk(10);
  endtask

  // expected pull_low for frame bit k (0..95) of the ATR
  function automatic logic exp_pull(input int k);
    logic [7:0] b;
    int idx;
    logic lvl;
    b = ATRV[8*(k/12) +: 8];
    idx = k % 12;
    if (idx == 0) lvl = 1'b0;
    else if (idx <= 8) lvl = b[idx-1];
    else if (idx == 9) lvl = ^b;
    else lvl = 1'b1;
    return ~lvl;
  endfunction

  task automatic check_atr(input string tag);
    for (int k = 0; k < NB*12; k++) begin
      chk(io_pull_low == exp_pull(k), {tag, " R5 frame bit"}, io_pull_low, exp_pull(k));
      card_pulse(BITC);
    end
    chk(io_pull_low == 1'b0, "R6 released after ATR", io_pull_low, 0);
    card_pulse(6);
    chk(io_pull_low == 1'b0, "R6 stays released", io_pull_low, 0);
  endtask

  initial begin
    // Async, late rise: counter already saturated
    power_up(1'b0);
    chk(mode_async == 1'b0, "R2 no mode before rise", mode_async, 0);
    for (int i = 0; i < COLD + 3; i++) begin
      card_pulse(1);
      chk(io_pull_low == 1'b0, "R3 released while waiting", io_pull_low, 0);
    end
    chk(sync_ready == 1'b0, "R8 ready absent in async path", sync_ready, 0);
    card_rst = 1'b1; wait_clk(SETTLE);
    chk(mode_async == 1'b1, "R2 cold reset selects async", mode_async, 1);
    chk(io_pull_low == 1'b1, "R4 ATR starts at saturated count", io_pull_low, 1);
    check_atr("late");
    // Lock: second cold-reset sequence
    card_rst = 1'b0; wait_clk(SETTLE);
    card_pulse(COLD + 2);
    card_rst = 1'b1; wait_clk(SETTLE);
    for (int i = 0; i < 20; i++) begin
      card_pulse(1);
      chk(io_pull_low == 1'b0, "R7 no second ATR", io_pull_low, 0);
    end
    chk(mode_async == 1'b1 && sync_ready == 1'b0, "R7 async locked", mode_async, 1);

    // Async, early rise after three clocks
    power_up(1'b0);
    card_pulse(3);
    card_rst = 1'b1; wait_clk(SETTLE);
    chk(mode_async == 1'b1, "R2 early rise selects async", mode_async, 1);
    chk(io_pull_low == 1'b0, "R4 ATR held back", io_pull_low, 0);
    card_pulse(COLD - 4);
    chk(io_pull_low == 1'b0, "R4 held at COLD-1 edges", io_pull_low, 0);
    card_pulse(1);
    chk(io_pull_low == 1'b1, "R4 start at COLD-th edge", io_pull_low, 1);
    check_atr("early");

    // Sync path
    power_up(1'b1);
    chk(mode_async == 1'b0 && sync_ready == 1'b0, "R1 sync default", {mode_async, sync_ready}, 0);
    for (int i = 1; i <= READY + 3; i++) begin
      card_pulse(1);
      chk(sync_ready == (i >= READY), "R8 ready after fifth edge", sync_ready, int'(i >= READY));
      chk(io_pull_low == 1'b0, "R3 released in sync", io_pull_low, 0);
    end
    card_rst = 1'b0; wait_clk(SETTLE); card_pulse(3);
    card_rst = 1'b1; wait_clk(SETTLE); card_pulse(3);
    chk(mode_async == 1'b0 && sync_ready == 1'b1, "R1 sync kept after reset toggle", mode_async, 0);

    // POR returns async lock to sync
    power_up(1'b0);
    card_pulse(2); card_rst = 1'b1; wait_clk(SETTLE);
    chk(mode_async == 1'b1, "R7 async before por", mode_async, 1);
    power_up(1'b1);
    chk(mode_async == 1'b0, "R7 por clears async lock", mode_async, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule